// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block sits next to an SMBus host controller and takes care of the packet error code (PEC) byte. The controller hands it every byte of a transaction as a byte-wide stream, framed by a start strobe, an optional repeated-start strobe, a byte-valid strobe and a last-byte marker, with a direction bit taken at each start. The block passes each byte on to the bit-level engine one cycle later. At the end of a write it can append one extra byte. At the end of a read it can compare the final received byte against the checksum it has computed over the earlier bytes.

The checksum is CRC-8 with generator x^8+x^2+x+1. It covers every byte from the start strobe onwards, including the address bytes with their direction bit and the address byte that follows a repeated start. Two configuration bits select the behaviour: automatic-CRC enable and manual-PEC enable. The mode is sampled at the start strobe and held for the whole transaction. In automatic mode the block appends and checks the computed CRC, and it never sends the software PEC byte. With only manual mode set, it appends the software PEC byte to writes and checks nothing. With neither bit set, it only passes bytes through. Setting both bits is illegal: the block raises a sticky configuration-error flag and behaves as in automatic mode.

The block has three sticky status flags: device error, CRC error and configuration error. Software clears them by writing one to the matching clear bit.

Top module: `smbus_pec_unit`

## Requirements
- R1: The computed CRC uses polynomial 0x07, a starting value of 0x00, data processed MSB first and no final inversion. Over the ASCII bytes "123456789" it yields 0xF4.
- R2: In automatic mode, a write's last input byte leaves with `out_last` low. In the next cycle the block emits the CRC of all bytes since the start strobe, with `out_last` high.
- R3: In automatic mode, the final byte of a read is compared with the CRC of the preceding bytes. A mismatch sets both `sts_flags[0]` (device error) and `sts_flags[1]` (CRC error). A match sets neither.
- R4: In automatic mode, the appended byte is always the computed CRC and never the `sw_pec` value, and this holds even when manual mode is also enabled.
- R5: While both `cfg_auto_en` and `cfg_man_en` are high, `sts_flags[2]` (configuration error) becomes set from the next cycle.
- R6: With both enables low, a write gets no extra byte, `out_last` marks the input's last byte, and a read with a wrong final byte sets no flag.
- R7: With only `cfg_man_en` high, a write is followed by one extra byte equal to `sw_pec`, marked last. Reads are not checked.
- R8: `st_start` resets the CRC to 0x00. `st_restart` keeps the running CRC and only changes the direction to `st_rd`.
- R9: Status flags stay set until a cycle with `clr_valid` high and the flag's bit set in `clr_mask`. Such a cycle clears only the masked flags.
- R10: The mode is taken from the enable inputs at `st_start`. Changing the enables inside a transaction does not change that transaction's append or check.
- R11: Every input byte appears on `out_byte` with `out_valid` high exactly one cycle after its `st_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_en | input | 1 | Automatic CRC append/check enable |
| cfg_man_en | input | 1 | Manual PEC append enable |
| sw_pec | input | 8 | Software PEC byte, used only in manual mode |
| st_start | input | 1 | Start of transaction: clears CRC, samples mode and direction |
| st_restart | input | 1 | Repeated start: samples direction, keeps CRC |
| st_rd | input | 1 | Direction taken at start/restart (1 = read) |
| st_valid | input | 1 | Byte strobe |
| st_byte | input | 8 | Byte sent or received |
| st_last | input | 1 | Marks the last byte from the controller |
| clr_valid | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask, bit order as `sts_flags` |
| out_valid | output | 1 | Outgoing byte strobe |
| out_byte | output | 8 | Outgoing byte (passed through or appended) |
| out_last | output | 1 | Marks the final byte of the packet |
| sts_flags | output | 3 | Sticky flags: [0] device error, [1] CRC error, [2] configuration error |

## Verification
The bench aims at the repeated-start read. A design that cleared the CRC at the repeated start would flag a correct PEC as bad. It changes the enables inside a transaction; a design that decoded the mode live would append the software byte instead of the CRC. It also uses the illegal both-enabled setting, where a design that gave priority to manual mode would send `sw_pec`. Partial clears and the standard check value 0xF4 expose flags that clear together or a CRC that is bit-reversed or inverted.

// File: rtl/smbus_pec_pkg.sv
// Shared constants and types of the SMBus PEC engine.
// Assumes an 8-bit byte stream; the flag indices fix the sts_flags layout.
package smbus_pec_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned FLAG_N   = 3;
    localparam int unsigned FLAG_DEV = 0;
    localparam int unsigned FLAG_CRC = 1;
    localparam int unsigned FLAG_CFG = 2;

    typedef enum logic [1:0] {
        PM_PASS   = 2'd0,
        PM_MANUAL = 2'd1,
        PM_AUTO   = 2'd2
    } pec_mode_e;

    // Automatic mode wins over manual mode when both are set.
    function automatic pec_mode_e pick_mode(input logic auto_en, input logic man_en);
        if (auto_en)
            return PM_AUTO;
        else if (man_en)
            return PM_MANUAL;
        else
            return PM_PASS;
    endfunction

endpackage

// File: rtl/smbus_pec_crc8.sv
// Running CRC accumulator: one whole byte folded in per update cycle.
// Assumes clear and upd are never high together; clear takes priority anyway.
module smbus_pec_crc8
    import smbus_pec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07,
    parameter logic [BYTE_W-1:0] INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc_q,
    output logic [BYTE_W-1:0] crc_nxt
);

    localparam int unsigned STAGES = BYTE_W;

    logic [STAGES:0][BYTE_W-1:0] stg;

    // Seed the shift chain with the data XORed into the current remainder.
    assign stg[0] = crc_q ^ din;

    // One shift/reduce stage per data bit, MSB first.
    for (genvar i = 0; i < STAGES; i++) begin : g_bit
        assign stg[i+1] = stg[i][BYTE_W-1] ? ({stg[i][BYTE_W-2:0], 1'b0} ^ POLY)
                                           :  {stg[i][BYTE_W-2:0], 1'b0};
    end

    assign crc_nxt = stg[STAGES];

    // Remainder register: reset/clear to INIT, else take the folded byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= INIT;
        else if (clear)
            crc_q <= INIT;
        else if (upd)
            crc_q <= crc_nxt;
    end

endmodule

// File: rtl/smbus_pec_seq.sv
// Transaction sequencer: latches mode and direction, forwards bytes with one
// cycle of latency, appends the PEC byte after a write and checks it on a read.
// Assumes the controller leaves one idle byte slot after a write's last byte
// whenever an append is due, and never sends a byte in a start cycle.
module smbus_pec_seq
    import smbus_pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_start,
    input  logic              st_restart,
    input  logic              st_rd,
    input  logic              st_valid,
    input  logic [BYTE_W-1:0] st_byte,
    input  logic              st_last,
    input  logic              cfg_auto_en,
    input  logic              cfg_man_en,
    input  logic [BYTE_W-1:0] sw_pec,
    input  logic [BYTE_W-1:0] crc_q,
    input  logic [BYTE_W-1:0] crc_nxt,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    output logic              chk_bad,
    output pec_mode_e         mode_cur,
    output logic              dir_rd_cur
);

    pec_mode_e         mode_q;
    logic              rd_q;
    logic              app_pend;
    logic [BYTE_W-1:0] app_byte;
    logic              wants_app;
    logic              end_byte;

    assign end_byte  = st_valid && st_last;
    assign wants_app = end_byte && !rd_q && (mode_q != PM_PASS);
    assign chk_bad   = end_byte && rd_q && (mode_q == PM_AUTO) && (st_byte != crc_q);

    assign mode_cur   = mode_q;
    assign dir_rd_cur = rd_q;

    // Hold the mode and direction for the running transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_PASS;
            rd_q   <= 1'b0;
        end else if (st_start) begin
            mode_q <= pick_mode(cfg_auto_en, cfg_man_en);
            rd_q   <= st_rd;
        end else if (st_restart) begin
            rd_q   <= st_rd;
        end
    end

    // Stage the byte to append: the computed CRC in auto mode, else software PEC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_pend <= 1'b0;
            app_byte <= '0;
        end else begin
            app_pend <= wants_app;
            if (wants_app)
                app_byte <= (mode_q == PM_AUTO) ? crc_nxt : sw_pec;
        end
    end

    // Output register: forward the input byte, else emit a pending append.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_last  <= 1'b0;
        end else if (st_valid) begin
            out_valid <= 1'b1;
            out_byte  <= st_byte;
            out_last  <= st_last && !wants_app;
        end else if (app_pend) begin
            out_valid <= 1'b1;
            out_byte  <= app_byte;
            out_last  <= 1'b1;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

endmodule

// File: rtl/smbus_pec_status.sv
// Sticky status flags with write-one-to-clear; a set wins over a clear
// of the same flag in the same cycle.
module smbus_pec_status
    import smbus_pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              clr_valid,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] flags
);

    // One sticky bit per flag.
    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[f] <= 1'b0;
            else if (set_vec[f])
                flags[f] <= 1'b1;
            else if (clr_valid && clr_mask[f])
                flags[f] <= 1'b0;
        end
    end

endmodule

// File: rtl/smbus_pec_unit.sv
// Top of the SMBus PEC engine: CRC accumulator, sequencer and status flags.
// Assumes the byte-stream framing described for smbus_pec_seq.
module smbus_pec_unit
    import smbus_pec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'h07,
    parameter logic [BYTE_W-1:0] CRC_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto_en,
    input  logic              cfg_man_en,
    input  logic [BYTE_W-1:0] sw_pec,
    input  logic              st_start,
    input  logic              st_restart,
    input  logic              st_rd,
    input  logic              st_valid,
    input  logic [BYTE_W-1:0] st_byte,
    input  logic              st_last,
    input  logic              clr_valid,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    output logic [FLAG_N-1:0] sts_flags
);

    logic [BYTE_W-1:0] crc_q;
    logic [BYTE_W-1:0] crc_nxt;
    logic              chk_bad;
    logic [FLAG_N-1:0] set_vec;
    pec_mode_e         mode_cur;
    logic              dir_rd_cur;

    smbus_pec_crc8 #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (st_start),
        .upd     (st_valid),
        .din     (st_byte),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    smbus_pec_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_start    (st_start),
        .st_restart  (st_restart),
        .st_rd       (st_rd),
        .st_valid    (st_valid),
        .st_byte     (st_byte),
        .st_last     (st_last),
        .cfg_auto_en (cfg_auto_en),
        .cfg_man_en  (cfg_man_en),
        .sw_pec      (sw_pec),
        .crc_q       (crc_q),
        .crc_nxt     (crc_nxt),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_last    (out_last),
        .chk_bad     (chk_bad),
        .mode_cur    (mode_cur),
        .dir_rd_cur  (dir_rd_cur)
    );

    // Route the event sources onto the flag positions.
    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_DEV] = chk_bad;
        set_vec[FLAG_CRC] = chk_bad;
        set_vec[FLAG_CFG] = cfg_auto_en && cfg_man_en;
    end

    smbus_pec_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_valid (clr_valid),
        .clr_mask  (clr_mask),
        .flags     (sts_flags)
    );

endmodule

// File: rtl/smbus_pec_unit_chk.sv
// Property checker for smbus_pec_unit, attached through bind below.
module smbus_pec_unit_chk
    import smbus_pec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_auto_en,
    input logic              cfg_man_en,
    input logic              st_start,
    input logic              st_valid,
    input logic [BYTE_W-1:0] st_byte,
    input logic              st_last,
    input logic              clr_valid,
    input logic [FLAG_N-1:0] clr_mask,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_last,
    input logic [FLAG_N-1:0] sts_flags,
    input pec_mode_e         mode_cur,
    input logic              dir_rd_cur
);

    // R5: conflicting enables raise the configuration flag.
    p_cfg_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en && cfg_man_en) |=> sts_flags[FLAG_CFG]);

    // R2: auto write end gives a non-final byte then a final appended byte.
    p_auto_append_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_last && !st_start && !dir_rd_cur && mode_cur == PM_AUTO)
        |=> (out_valid && !out_last) ##1 (out_valid && out_last));

    // R6: pass-through marks the input's last byte as final.
    p_pass_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_last && mode_cur == PM_PASS) |=> (out_valid && out_last));

    // R3: a CRC error never appears without the device error.
    p_dual_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_flags[FLAG_CRC]) |-> sts_flags[FLAG_DEV]);

    // R9: an uncleared CRC error flag stays set.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_flags[FLAG_CRC] && !(clr_valid && clr_mask[FLAG_CRC])) |=> sts_flags[FLAG_CRC]);

    // R11: each input byte shows up one cycle later.
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (out_valid && out_byte == $past(st_byte)));

endmodule

bind smbus_pec_unit smbus_pec_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_auto_en (cfg_auto_en),
    .cfg_man_en  (cfg_man_en),
    .st_start    (st_start),
    .st_valid    (st_valid),
    .st_byte     (st_byte),
    .st_last     (st_last),
    .clr_valid   (clr_valid),
    .clr_mask    (clr_mask),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_last    (out_last),
    .sts_flags   (sts_flags),
    .mode_cur    (mode_cur),
    .dir_rd_cur  (dir_rd_cur)
);

// File: tb/smbus_pec_unit_bench.sv
module smbus_pec_unit_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;   // 0 pass, 1 manual, 2 auto, 3 both
        logic        rd;
        logic        good;
        logic [2:0]  nb;
        logic [31:0] data;
        logic [7:0]  sw;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd2, 1'b0, 1'b0, 3'd3, 32'h5A123400, 8'hEE},
        '{2'd2, 1'b1, 1'b1, 3'd2, 32'hA50F0000, 8'h00},
        '{2'd2, 1'b1, 1'b0, 3'd3, 32'h11223300, 8'h00},
        '{2'd0, 1'b0, 1'b0, 3'd2, 32'h44550000, 8'h3C},
        '{2'd0, 1'b1, 1'b0, 3'd1, 32'h7E000000, 8'h00},
        '{2'd1, 1'b0, 1'b0, 3'd4, 32'h01020304, 8'h9C},
        '{2'd1, 1'b1, 1'b0, 3'd2, 32'hF0F10000, 8'h00},
        '{2'd3, 1'b0, 1'b0, 3'd3, 32'hDEADBE00, 8'h00},
        '{2'd3, 1'b1, 1'b0, 3'd1, 32'h80000000, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_auto_en = 1'b0, cfg_man_en = 1'b0;
    logic [7:0] sw_pec = '0;
    logic       st_start = 1'b0, st_restart = 1'b0, st_rd = 1'b0;
    logic       st_valid = 1'b0, st_last = 1'b0;
    logic [7:0] st_byte = '0;
    logic       clr_valid = 1'b0;
    logic [2:0] clr_mask = '0;
    logic       out_valid, out_last;
    logic [7:0] out_byte;
    logic [2:0] sts_flags;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [7:0] mon_b [16];
    logic       mon_l [16];
    int         mon_c [16];
    int         mon_n = 0;

    smbus_pec_unit u_smbus_pec_unit (
        .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en), .cfg_man_en(cfg_man_en),
        .sw_pec(sw_pec), .st_start(st_start), .st_restart(st_restart), .st_rd(st_rd),
        .st_valid(st_valid), .st_byte(st_byte), .st_last(st_last),
        .clr_valid(clr_valid), .clr_mask(clr_mask),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
        .sts_flags(sts_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[7] ^ d[k];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge, record any output byte, then drive.
    task automatic step(input logic s, input logic rs, input logic v,
                        input logic [7:0] b, input logic l);
        @(negedge clk);
        cyc++;
        if (out_valid && mon_n < 16) begin
            mon_b[mon_n] = out_byte;
            mon_l[mon_n] = out_last;
            mon_c[mon_n] = cyc;
            mon_n++;
        end
        st_start = s; st_restart = rs; st_valid = v; st_byte = b; st_last = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic clear_all();
        cfg_auto_en = 1'b0; cfg_man_en = 1'b0;
        idle(1);
        clr_valid = 1'b1; clr_mask = 3'b111;
        idle(1);
        clr_valid = 1'b0; clr_mask = 3'b000;
        idle(1);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [7:0] crc = 8'h00;
        logic [7:0] b;
        int         exp_n;
        logic [2:0] exp_sts;
        bit         app;
        cfg_auto_en = v.mode[1]; cfg_man_en = v.mode[0]; sw_pec = v.sw;
        st_rd = v.rd;
        mon_n = 0;
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < int'(v.nb); i++) begin
            b = v.data[31-8*i -: 8];
            crc = ref_crc(crc, b);
            step(1'b0, 1'b0, 1'b1, b, !v.rd && (i == int'(v.nb) - 1));
        end
        if (v.rd)
            step(1'b0, 1'b0, 1'b1, v.good ? crc : (crc ^ 8'hFF), 1'b1);
        idle(3);
        app   = !v.rd && (v.mode != 2'd0);
        exp_n = int'(v.nb) + (v.rd ? 1 : 0) + (app ? 1 : 0);
        // R2 R6 R7: byte count of the packet.
        check(mon_n == exp_n, $sformatf("R2/R6/R7 vec%0d count", idx), mon_n, exp_n);
        for (int i = 0; i < int'(v.nb) && i < mon_n; i++)
            check(mon_b[i] == v.data[31-8*i -: 8], $sformatf("R11 vec%0d byte%0d", idx, i),
                  mon_b[i], v.data[31-8*i -: 8]);
        if (mon_n == exp_n) begin
            check(mon_l[exp_n-1] == 1'b1, $sformatf("R2 vec%0d final marker", idx), mon_l[exp_n-1], 1);
            if (exp_n > 1)
                check(mon_l[exp_n-2] == 1'b0, $sformatf("R2 vec%0d early marker", idx), mon_l[exp_n-2], 0);
            if (app && v.mode[1])   // R4: auto appends computed CRC, never sw_pec
                check(mon_b[exp_n-1] == crc, $sformatf("R4 vec%0d crc byte", idx), mon_b[exp_n-1], crc);
            if (app && !v.mode[1])  // R7: manual appends sw_pec
                check(mon_b[exp_n-1] == v.sw, $sformatf("R7 vec%0d sw byte", idx), mon_b[exp_n-1], v.sw);
        end
        exp_sts = '0;
        if (v.rd && v.mode[1] && !v.good) exp_sts[1:0] = 2'b11;
        if (v.mode == 2'd3) exp_sts[2] = 1'b1;
        // R3 R5 R6: status outcome.
        check(sts_flags == exp_sts, $sformatf("R3/R5 vec%0d status", idx), sts_flags, exp_sts);
        clear_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] crc;
        int first_cyc;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // Reset state.
        check(sts_flags == 3'b000, "R9 reset flags", sts_flags, 0);
        check(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);

        for (int i = 0; i < 9; i++) run_vec(VECS[i], i);

        // R1 and R11: standard check string in auto write.
        cfg_auto_en = 1'b1; st_rd = 1'b0; mon_n = 0;
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        first_cyc = cyc + 1;
        for (int i = 0; i < 9; i++)
            step(1'b0, 1'b0, 1'b1, 8'h31 + 8'(i), i == 8);
        idle(3);
        check(mon_n == 10 && mon_b[9] == 8'hF4, "R1 check value", mon_b[9], 8'hF4);
        check(mon_c[0] == first_cyc + 1, "R11 one-cycle latency", mon_c[0], first_cyc + 1);
        clear_all();

        // R8: read with repeated start, CRC spans both address bytes.
        for (int pass = 0; pass < 2; pass++) begin
            cfg_auto_en = 1'b1; st_rd = 1'b0;
            crc = ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h20), 8'h07), 8'h21), 8'hC3);
            step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
            step(1'b0, 1'b0, 1'b1, 8'h20, 1'b0);
            step(1'b0, 1'b0, 1'b1, 8'h07, 1'b0);
            st_rd = 1'b1;
            step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
            step(1'b0, 1'b0, 1'b1, 8'h21, 1'b0);
            step(1'b0, 1'b0, 1'b1, 8'hC3, 1'b0);
            step(1'b0, 1'b0, 1'b1, (pass == 0) ? crc : ~crc, 1'b1);
            idle(3);
            check(sts_flags == ((pass == 0) ? 3'b000 : 3'b011),
                  $sformatf("R8 restart read pass%0d", pass), sts_flags, (pass == 0) ? 0 : 3);
            if (pass == 0) clear_all();
        end

        // R9: partial clear leaves the other flag set.
        idle(4);
        check(sts_flags == 3'b011, "R9 sticky hold", sts_flags, 3);
        clr_valid = 1'b1; clr_mask = 3'b001;
        idle(1);
        clr_valid = 1'b0; clr_mask = 3'b000;
        idle(1);
        check(sts_flags == 3'b010, "R9 partial clear", sts_flags, 2);
        clr_valid = 1'b1; clr_mask = 3'b010;
        idle(1);
        clr_valid = 1'b0; clr_mask = 3'b000;
        idle(1);
        check(sts_flags == 3'b000, "R9 second clear", sts_flags, 0);

        // R10: enables flipped mid-transaction do not change the append.
        cfg_auto_en = 1'b1; cfg_man_en = 1'b0; sw_pec = 8'h5B; st_rd = 1'b0; mon_n = 0;
        crc = ref_crc(ref_crc(8'h00, 8'h6D), 8'h92);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h6D, 1'b0);
        cfg_auto_en = 1'b0; cfg_man_en = 1'b1;
        step(1'b0, 1'b0, 1'b1, 8'h92, 1'b1);
        idle(3);
        check(mon_n == 3 && mon_b[2] == crc, "R10 mode held", mon_b[2], crc);
        clear_all();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule